// File: doc/BRIEF.md
# Accumulator Readout Formatter

This block turns one wide signed accumulator value into a 32-bit word for the register file. Each read request carries the accumulator value and a set of mode controls. The controls select one of four interpretations: fractional, signed integer, unsigned integer, or a raw copy. For fractional reads, the controls also choose between a 16-bit and a 32-bit result, turn on round-half-to-even, and turn on clamping of results that overflow. The block computes the word in one combinational pass and captures it in a single output register.

Both the request side and the result side are valid/ready streams. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-to-back requests run at full rate when the consumer keeps `out_ready` high. While `out_valid` is high and `out_ready` is low, the result word is held unchanged and no new request is accepted.

Top module: `acc_readout_fmt`

## Requirements
- R1: `in_kind` code 0 selects a fractional read; with `in_half`=1 the result is accumulator bits [39:24] in `out_data[15:0]`, rounded up when bits [23:0] exceed 0x800000 and rounded to even when they equal 0x800000, regardless of `in_round`.
- R2: A fractional read with `in_half`=0 and `in_round`=1 shifts the accumulator right arithmetically by 8, rounding up when bits [7:0] exceed 0x80 and rounding to even when they equal 0x80.
- R3: A fractional read with `in_half`=0 and `in_round`=0 returns the accumulator shifted right arithmetically by 8, truncated to 32 bits.
- R4: In 16-bit fractional mode with `in_sat`=1, a rounded value outside the signed 16-bit range gives 0x7FFF when positive and 0x8000 when negative; with `in_sat`=0 it gives the low 16 bits of the rounded value. Bits [31:16] are always zero in this mode.
- R5: In 32-bit fractional mode with `in_sat`=1, a result outside the signed 32-bit range gives 0x7FFFFFFF when positive and 0x80000000 when negative; with `in_sat`=0 it gives the low 32 bits.
- R6: `in_kind` code 1 (signed integer) returns accumulator bits [31:0] when the value fits in a signed 32-bit range, and otherwise 0x7FFFFFFF or 0x80000000 by sign. `in_sat`, `in_round` and `in_half` have no effect on this kind.
- R7: `in_kind` code 2 (unsigned integer) returns bits [31:0] when bits [47:32] are all zero, and otherwise 0xFFFFFFFF.
- R8: `in_kind` code 3 (raw) returns accumulator bits [31:0] unchanged, whatever the other controls are.
- R9: The result of an accepted request appears with `out_valid` high on the clock edge after acceptance. `in_ready` equals `!out_valid || out_ready`.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R11: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Read request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_acc | input | 48 | Accumulator value to format (two's complement) |
| in_kind | input | 2 | 0 fractional, 1 signed integer, 2 unsigned integer, 3 raw |
| in_round | input | 1 | Round-half-even for 32-bit fractional reads |
| in_half | input | 1 | 16-bit fractional result |
| in_sat | input | 1 | Clamp fractional results that overflow |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Formatted result |

## Verification
The bench builds the block with its default parameters: a 48-bit accumulator, a 32-bit result, a 16-bit short result and rounding points at bits 8 and 24. At these widths, hand-picked accumulator values can sit exactly at the rounding halfway points of both positions. They can also sit on the sign boundaries of both clamp ranges and on the carry that pushes a rounded value just past the 16-bit limit. Random values spread across all four read kinds run while random consumer stalls apply back-pressure.

// File: rtl/acc_fmt_pkg.sv
package acc_fmt_pkg;
  typedef enum logic [1:0] {
    KIND_FRAC = 2'd0,
    KIND_SINT = 2'd1,
    KIND_UINT = 2'd2,
    KIND_RAW  = 2'd3
  } rd_kind_e;

  typedef struct packed {
    rd_kind_e kind;
    logic     rnd;
    logic     half;
    logic     sat;
  } rd_mode_t;
endpackage

// File: rtl/acc_round_even.sv
// Drops DROP low bits of a signed value, optionally rounding half to even.
// The output keeps one extra bit so a round-up carry never wraps.
module acc_round_even #(
  parameter int IN_W = 48,
  parameter int DROP = 8,
  localparam int KEEP_W = IN_W - DROP + 1
) (
  input  logic [IN_W-1:0]   x,
  input  logic              en,
  output logic [KEEP_W-1:0] y
);
  localparam logic [DROP-1:0] HALF = {1'b1, {(DROP-1){1'b0}}};

  logic [KEEP_W-1:0] kept;
  logic [DROP-1:0]   rem;
  logic              bump;

  always_comb begin
    kept = {x[IN_W-1], x[IN_W-1:DROP]};
    rem  = x[DROP-1:0];
    bump = en && ((rem > HALF) || ((rem == HALF) && kept[0]));
    y    = kept + KEEP_W'(bump);
  end
endmodule

// File: rtl/acc_sat_signed.sv
// Narrows a signed value to OUT_W bits; when enabled, values that do not
// fit clamp to the largest or smallest OUT_W-bit signed number by sign.
module acc_sat_signed #(
  parameter int IN_W  = 41,
  parameter int OUT_W = 32,
  localparam int TOP_W = IN_W - OUT_W + 1
) (
  input  logic [IN_W-1:0]  x,
  input  logic             en,
  output logic [OUT_W-1:0] y
);
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic fits;

  always_comb begin
    fits = (x[IN_W-1:OUT_W-1] == {TOP_W{x[IN_W-1]}});
    if (!en || fits) y = x[OUT_W-1:0];
    else if (x[IN_W-1]) y = NEG_MIN;
    else y = POS_MAX;
  end
endmodule

// File: rtl/acc_fmt_stage.sv
// Single output register with valid/ready handshake.
module acc_fmt_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_valid,
  output logic         load_ready,
  input  logic [W-1:0] load_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign load_ready = !out_valid || out_ready;
  assign take       = load_valid && load_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= load_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_accept_then_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (out_valid && out_data == $past(load_data)));

  assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/acc_readout_fmt.sv
module acc_readout_fmt #(
  parameter int ACC_W      = 48,
  parameter int RES_W      = 32,
  parameter int SHORT_W    = 16,
  parameter int FRAC_SHIFT = 8,
  parameter int SHORT_SHIFT = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ACC_W-1:0] in_acc,
  input  logic [1:0]       in_kind,
  input  logic             in_round,
  input  logic             in_half,
  input  logic             in_sat,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RES_W-1:0] out_data
);
  import acc_fmt_pkg::*;

  localparam int LONG_KEEP_W  = ACC_W - FRAC_SHIFT + 1;
  localparam int SHORT_KEEP_W = ACC_W - SHORT_SHIFT + 1;
  localparam int UPPER_W      = ACC_W - RES_W;

  rd_mode_t mode;
  assign mode = '{kind: rd_kind_e'(in_kind), rnd: in_round, half: in_half, sat: in_sat};

  // Fractional, 32-bit result
  logic [LONG_KEEP_W-1:0] long_rnd;
  logic [RES_W-1:0]       long_res;

  acc_round_even #(.IN_W(ACC_W), .DROP(FRAC_SHIFT)) u_round_long (
    .x(in_acc), .en(mode.rnd), .y(long_rnd)
  );

  acc_sat_signed #(.IN_W(LONG_KEEP_W), .OUT_W(RES_W)) u_sat_long (
    .x(long_rnd), .en(mode.sat), .y(long_res)
  );

  // Fractional, short result: always rounded
  logic [SHORT_KEEP_W-1:0] short_rnd;
  logic [SHORT_W-1:0]      short_res;

  acc_round_even #(.IN_W(ACC_W), .DROP(SHORT_SHIFT)) u_round_short (
    .x(in_acc), .en(1'b1), .y(short_rnd)
  );

  acc_sat_signed #(.IN_W(SHORT_KEEP_W), .OUT_W(SHORT_W)) u_sat_short (
    .x(short_rnd), .en(mode.sat), .y(short_res)
  );

  // Signed integer: always clamped
  logic [RES_W-1:0] sint_res;

  acc_sat_signed #(.IN_W(ACC_W), .OUT_W(RES_W)) u_sat_int (
    .x(in_acc), .en(1'b1), .y(sint_res)
  );

  // Unsigned integer
  logic [RES_W-1:0] uint_res;
  assign uint_res = (in_acc[ACC_W-1:RES_W] == '0) ? in_acc[RES_W-1:0] : '1;

  // Kind select
  logic [RES_W-1:0] fmt_word;

  always_comb begin
    unique case (mode.kind)
      KIND_FRAC: fmt_word = mode.half ? {{(RES_W-SHORT_W){1'b0}}, short_res} : long_res;
      KIND_SINT: fmt_word = sint_res;
      KIND_UINT: fmt_word = uint_res;
      default:   fmt_word = in_acc[RES_W-1:0];
    endcase
  end

  acc_fmt_stage #(.W(RES_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .load_valid(in_valid), .load_ready(in_ready), .load_data(fmt_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  logic take;
  assign take = in_valid && in_ready;

  assert_uint_over_all_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_kind == 2'd2 && in_acc[ACC_W-1:RES_W] != {UPPER_W{1'b0}})
      |=> (out_data == {RES_W{1'b1}}));

  assert_sint_keeps_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_kind == 2'd1) |=> (out_data[RES_W-1] == $past(in_acc[ACC_W-1])));

  assert_short_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_kind == 2'd0 && in_half) |=> (out_data[RES_W-1:SHORT_W] == '0));

  assert_raw_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_kind == 2'd3) |=> (out_data == $past(in_acc[RES_W-1:0])));
endmodule

// File: tb/acc_readout_fmt_bench.sv
`timescale 1ns/1ps
module acc_readout_fmt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_acc = '0;
  logic [1:0]  in_kind = 2'd0;
  logic        in_round = 1'b0;
  logic        in_half = 1'b0;
  logic        in_sat = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit stall_on = 1'b0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  acc_readout_fmt u_acc_readout_fmt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_kind(in_kind), .in_round(in_round), .in_half(in_half),
    .in_sat(in_sat), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [47:0] acc, input logic [1:0] kind,
                                        input bit rnd, input bit half, input bit sat);
    longint a, q, rem;
    a = longint'({{16{acc[47]}}, acc});
    if (kind == 2'd3) return acc[31:0];
    if (kind == 2'd2) return (acc[47:32] == 16'h0) ? acc[31:0] : 32'hFFFF_FFFF;
    if (kind == 2'd1) begin
      if (a > 64'sh7FFF_FFFF) return 32'h7FFF_FFFF;
      if (a < -64'sh8000_0000) return 32'h8000_0000;
      return acc[31:0];
    end
    if (half) begin
      q = a >>> 24;
      rem = a & 64'hFF_FFFF;
      if (rem > 64'h80_0000) q = q + 1;
      else if (rem == 64'h80_0000) q = q + (q & 1);
      if (sat && q > 32767) return 32'h0000_7FFF;
      if (sat && q < -32768) return 32'h0000_8000;
      return {16'h0, q[15:0]};
    end
    q = a >>> 8;
    if (rnd) begin
      rem = a & 64'hFF;
      if (rem > 64'h80) q = q + 1;
      else if (rem == 64'h80) q = q + (q & 1);
    end
    if (sat && q > 64'sh7FFF_FFFF) return 32'h7FFF_FFFF;
    if (sat && q < -64'sh8000_0000) return 32'h8000_0000;
    return q[31:0];
  endfunction

  function automatic string tag_of(input logic [1:0] kind, input bit rnd, input bit half);
    case (kind)
      2'd1: return "R6";
      2'd2: return "R7";
      2'd3: return "R8";
      default: return half ? "R1" : (rnd ? "R2" : "R3");
    endcase
  endfunction

  task automatic send(input logic [47:0] acc, input logic [1:0] kind, input bit rnd,
                      input bit half, input bit sat, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_acc = acc; in_kind = kind;
    in_round = rnd; in_half = half; in_sat = sat;
    #1;
    check("R9", {31'd0, in_ready}, {31'd0, (!out_valid || out_ready)});
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(acc, kind, rnd, half, sat));
    tag_q.push_back(tag);
    @(negedge clk);
    #1;
    check("R9", {31'd0, out_valid}, 32'd1);
    in_valid = 1'b0;
  endtask

  // Consumer back-pressure
  always @(negedge clk) begin
    if (stall_on) out_ready <= (($urandom % 10) < 7);
    else out_ready <= 1'b1;
  end

  // Monitor / scoreboard
  initial begin
    logic [31:0] held;
    bit was_stalled;
    was_stalled = 1'b0;
    held = '0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid) begin
        if (was_stalled) check("R10", out_data, held);
        if (out_ready) begin
          if (exp_q.size() == 0) begin
            n_checks++; n_fails++;
            $display("FAIL R9: got %h expected no result", out_data);
          end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, out_data, e);
          end
          was_stalled = 1'b0;
        end else begin
          was_stalled = 1'b1;
          held = out_data;
        end
      end else begin
        was_stalled = 1'b0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R11", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: 16-bit fractional rounding at bit 24
    send({24'h000012, 24'h800000}, 2'd0, 0, 1, 0, "R1");
    send({24'h000013, 24'h800000}, 2'd0, 1, 1, 0, "R1");
    send({24'h000012, 24'h800001}, 2'd0, 0, 1, 0, "R1");
    send({24'h000012, 24'h7FFFFF}, 2'd0, 0, 1, 1, "R1");
    send({24'hFFFFFF, 24'h800000}, 2'd0, 0, 1, 0, "R1");
    // R2: 32-bit fractional rounding at bit 8
    send(48'h0000_0000_1280, 2'd0, 1, 0, 0, "R2");
    send(48'h0000_0000_1380, 2'd0, 1, 0, 0, "R2");
    send(48'h0000_0000_1281, 2'd0, 1, 0, 0, "R2");
    send(48'hFFFF_FFFF_FF80, 2'd0, 1, 0, 0, "R2");
    // R3: truncation
    send(48'h0000_0000_13FF, 2'd0, 0, 0, 0, "R3");
    send(48'hFFFF_FFFF_FFFF, 2'd0, 0, 0, 0, "R3");
    // R4: 16-bit clamp
    send({24'h008000, 24'h000000}, 2'd0, 0, 1, 1, "R4");
    send({24'hFF7FFF, 24'h000000}, 2'd0, 0, 1, 1, "R4");
    send({24'h008000, 24'h000000}, 2'd0, 0, 1, 0, "R4");
    send({24'h007FFF, 24'h800001}, 2'd0, 0, 1, 1, "R4");
    send({24'hFF8000, 24'h000000}, 2'd0, 0, 1, 1, "R4");
    // R5: 32-bit clamp
    send(48'h0080_0000_0000, 2'd0, 0, 0, 1, "R5");
    send(48'h0080_0000_0000, 2'd0, 0, 0, 0, "R5");
    send(48'hFF7F_FFFF_FF00, 2'd0, 1, 0, 1, "R5");
    send(48'h007F_FFFF_FF80, 2'd0, 1, 0, 1, "R5");
    // R6: signed integer
    send(48'h0000_8000_0000, 2'd1, 0, 0, 0, "R6");
    send(48'hFFFF_7FFF_FFFF, 2'd1, 1, 1, 0, "R6");
    send(48'hFFFF_8000_0000, 2'd1, 0, 0, 1, "R6");
    send(48'h0000_7FFF_FFFF, 2'd1, 1, 0, 0, "R6");
    // R7: unsigned integer
    send(48'h0001_0000_0005, 2'd2, 0, 0, 0, "R7");
    send(48'h0000_DEAD_BEEF, 2'd2, 1, 1, 1, "R7");
    send(48'h8000_0000_0000, 2'd2, 0, 0, 0, "R7");
    // R8: raw
    send(48'h1234_5678_9ABC, 2'd3, 1, 1, 1, "R8");
    send(48'hFFFF_0000_0001, 2'd3, 0, 0, 0, "R8");

    // Random phase with back-pressure (R10)
    stall_on = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [47:0] acc;
      logic [1:0]  kind;
      bit rnd, half, sat;
      int shape;
      shape = $urandom % 4;
      acc = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      if (shape == 1) acc = {{17{acc[31]}}, acc[30:0]};
      if (shape == 2) acc = {{8{acc[39]}}, acc[39:0]};
      if (shape == 3) acc[23:0] = (($urandom % 2) == 0) ? 24'h800000 : {acc[23:8], 8'h80};
      kind = 2'($urandom % 4);
      rnd  = 1'($urandom % 2);
      half = 1'($urandom % 2);
      sat  = 1'($urandom % 2);
      send(acc, kind, rnd, half, sat, tag_of(kind, rnd, half));
    end
    stall_on = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule